// File: doc/BRIEF.md
# Limit-Compare Interval Clock Interface

This block is a programmable interval clock that sits behind a set of one-cycle strobes driven by an I/O controller. A selectable-rate tick divider advances a count register. Each time the count reaches the value held in a limit register, a limit event is recorded, and the count can optionally restart from zero. Software reads the count and a composed status word, loads the limit, clears the count, and manages three interrupt flip-flops through a control word. The three flip-flops record a limit event, a missed (lost) limit event, and a request raised by software.

An interrupt request line is recomputed from the flip-flops and the interrupt-enable control bit. An interrupt poll handshake takes a pending request and returns the device number. If no request is pending, the poll is passed on to the next device in the chain. Once a request has been taken, the interrupt is active and requests are not recomputed until an end-of-interrupt strobe arrives.

Top module: `lcc_clock_if`

## Requirements
- R1: After reset the rate is 0 (stopped), the count and limit are 0, all three flip-flops and the request are clear, and the status word reads 16'h8000.
- R2: A control strobe with bit 3 set loads the rate from bits [2:0] and restarts the divider. At rate r > 0, a tick occurs every BASE_DIV<<(r-1) cycles. At rate 0 no tick occurs and the count holds.
- R3: A control strobe with bit 3 clear and bit 4 set performs a master reset. It returns every register to its reset value, including the stored control bits.
- R4: On a control strobe, bit 8 clears the limit, lost and system flip-flops together. Otherwise, when bit 9 is set, code [11:10] clears one flip-flop: 1 clears limit, 2 clears lost, 3 clears system, and 0 clears none.
- R5: The status strobe returns: bit 15 = 1 (device ok); [2:0] = rate; bit 3 = limit; bit 4 = lost; bit 5 = system; bit 6 = stored write-select bit; bit 7 = stored count-restart bit. All other bits are 0.
- R6: The read strobe returns the low 16 bits of the count register.
- R7: The write strobe clears the count when the stored control bit 6 is set. Otherwise it loads the limit from the data input. In a cycle with a write strobe, any tick is dropped.
- R8: Each tick increments the count. When the incremented value equals the limit, the limit flip-flop is set. If stored control bit 7 is set, the count becomes 0 instead of the incremented value.
- R9: A limit event that arrives while the limit flip-flop is already set also sets the lost flip-flop.
- R10: Requests are recomputed after a control strobe or a limit event when no interrupt is active, and always after an end-of-interrupt strobe. A recompute clears the active state and sets the request to ((limit or lost) and control bit 5) or system.
- R11: A poll with a request pending clears the request, sets the active state, asserts the acknowledge and drives DEV_NUM on the data output. A poll with no request pending asserts the pass-on output instead.
- R12: A set-interrupt strobe sets the system flip-flop and raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_stb_i | input | 1 | Control word strobe |
| stat_stb_i | input | 1 | Status read strobe |
| rd_stb_i | input | 1 | Count read strobe |
| wr_stb_i | input | 1 | Limit load / count clear strobe |
| setint_stb_i | input | 1 | Software interrupt strobe |
| eoi_stb_i | input | 1 | End-of-interrupt strobe (forces a recompute) |
| poll_i | input | 1 | Interrupt poll in |
| data_i | input | 16 | Control word or limit value |
| data_o | output | 16 | Status, count or device number |
| irq_req_o | output | 1 | Interrupt request |
| int_ack_o | output | 1 | Poll acknowledge |
| poll_o | output | 1 | Poll passed to next device |

## Verification
The assertions take for granted that at most one strobe, poll included, is high in any cycle. Priorities between strobes are therefore not checked by the properties, but ticks may still coincide with any strobe. The bench drives every stimulus through a single task that raises exactly one strobe per cycle, so it stays within that assumption. Meanwhile the free-running divider produces ticks that collide with control, write and poll strobes, which exercises the tick-versus-strobe precedence.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int DATA_W = 16;
  localparam int RATE_W = 3;

  // control word as seen on data_i[11:0]
  typedef struct packed {
    logic [1:0]        clr_code;   // [11:10]
    logic              clr_one;    // [9]
    logic              clr_all;    // [8]
    logic              cnt_rst;    // [7]
    logic              wr_sel;     // [6]
    logic              irq_en;     // [5]
    logic              mreset;     // [4]
    logic              rate_load;  // [3]
    logic [RATE_W-1:0] rate;       // [2:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ST_OK_BIT = DATA_W - 1;
endpackage

// File: rtl/lcc_tick_div.sv
module lcc_tick_div #(
  parameter int RATE_W   = 3,
  parameter int BASE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              tick_o
);
  localparam int NRATE = 1 << RATE_W;
  localparam int MAX_P = BASE_DIV << (NRATE - 2);
  localparam int DIV_W = $clog2(MAX_P) + 1;

  logic [DIV_W-1:0] period [NRATE];

  genvar g;
  generate
    for (g = 0; g < NRATE; g++) begin : g_period
      if (g == 0) begin : g_stop
        assign period[g] = '0;
      end else begin : g_run
        assign period[g] = DIV_W'(BASE_DIV << (g - 1));
      end
    end
  endgenerate

  logic [RATE_W-1:0] rate_q, rate_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              en;
  logic              run, at_end;

  assign run    = (rate_q != '0);
  assign at_end = run && (div_q == period[rate_q] - 1'b1);
  assign tick_o = at_end && !load_i && !clear_i;
  assign rate_o = rate_q;

  always_comb begin
    rate_d = rate_q;
    div_d  = div_q;
    en     = 1'b0;
    if (clear_i) begin
      rate_d = '0;
      div_d  = '0;
      en     = 1'b1;
    end else if (load_i) begin
      rate_d = rate_i;
      div_d  = '0;
      en     = 1'b1;
    end else if (run) begin
      div_d = at_end ? '0 : div_q + 1'b1;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      div_q  <= '0;
    end else if (en) begin
      rate_q <= rate_d;
      div_q  <= div_d;
    end
  end

  assert_stopped_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |-> !tick_o);
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (div_q == '0 && rate_q == $past(rate_i)));
endmodule

// File: rtl/lcc_count_cmp.sv
module lcc_count_cmp #(
  parameter int COUNT_W = 24,
  parameter int LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             wr_sel_i,
  input  logic             cnt_rst_i,
  input  logic [LIM_W-1:0] wdata_i,
  output logic [LIM_W-1:0] cnt_lo_o,
  output logic             hit_o
);
  logic [COUNT_W-1:0] count_q, count_d, count_inc;
  logic [LIM_W-1:0]   limit_q, limit_d;
  logic               count_en, limit_en;
  logic               tick_use, match;

  assign count_inc = count_q + 1'b1;
  assign match     = (count_inc == COUNT_W'(limit_q));
  assign tick_use  = tick_i && !wr_i && !clear_i;
  assign hit_o     = tick_use && match;
  assign cnt_lo_o  = count_q[LIM_W-1:0];

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    limit_d  = limit_q;
    limit_en = 1'b0;
    if (clear_i) begin
      count_d  = '0;
      count_en = 1'b1;
      limit_d  = '0;
      limit_en = 1'b1;
    end else if (wr_i) begin
      if (wr_sel_i) begin
        count_d  = '0;
        count_en = 1'b1;
      end else begin
        limit_d  = wdata_i;
        limit_en = 1'b1;
      end
    end else if (tick_use) begin
      count_d  = (match && cnt_rst_i) ? '0 : count_inc;
      count_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (limit_en) begin
      limit_q <= limit_d;
    end
  end

  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i && !clear_i) |=> (count_q == '0));
  assert_limit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wr_sel_i && !clear_i) |=> (limit_q == $past(wdata_i)));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i && !clear_i && !hit_o) |=> (count_q == $past(count_q) + 1'b1));
  assert_hit_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && cnt_rst_i) |=> (count_q == '0));
endmodule

// File: rtl/lcc_irq_ctl.sv
module lcc_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       ctl_i,
  input  logic       clr_all_i,
  input  logic       clr_one_i,
  input  logic [1:0] clr_code_i,
  input  logic       irq_en_i,
  input  logic       setint_i,
  input  logic       poll_i,
  input  logic       eoi_i,
  input  logic       hit_i,
  output logic       lim_o,
  output logic       lost_o,
  output logic       sys_o,
  output logic       req_o,
  output logic       act_o
);
  logic lim_q, lost_q, sys_q, req_q, act_q;
  logic lim_d, lost_d, sys_d, req_d, act_d;
  logic take, recompute;

  assign take      = poll_i && req_q;
  assign recompute = eoi_i || ((ctl_i || hit_i) && !act_q);

  always_comb begin
    lim_d  = lim_q;
    lost_d = lost_q;
    sys_d  = sys_q;
    if (clear_i) begin
      lim_d  = 1'b0;
      lost_d = 1'b0;
      sys_d  = 1'b0;
    end else begin
      if (ctl_i) begin
        if (clr_all_i) begin
          lim_d  = 1'b0;
          lost_d = 1'b0;
          sys_d  = 1'b0;
        end else if (clr_one_i) begin
          case (clr_code_i)
            2'd1:    lim_d  = 1'b0;
            2'd2:    lost_d = 1'b0;
            2'd3:    sys_d  = 1'b0;
            default: ;
          endcase
        end
      end
      if (setint_i) sys_d = 1'b1;
      if (hit_i) begin
        if (lim_d) lost_d = 1'b1;
        lim_d = 1'b1;
      end
    end
  end

  always_comb begin
    req_d = req_q;
    act_d = act_q;
    if (clear_i) begin
      req_d = 1'b0;
      act_d = 1'b0;
    end else if (take) begin
      req_d = 1'b0;
      act_d = 1'b1;
    end else if (setint_i) begin
      req_d = 1'b1;
    end else if (recompute) begin
      act_d = 1'b0;
      req_d = ((lim_d || lost_d) && irq_en_i) || sys_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= 1'b0;
      lost_q <= 1'b0;
      sys_q  <= 1'b0;
      req_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      lim_q  <= lim_d;
      lost_q <= lost_d;
      sys_q  <= sys_d;
      req_q  <= req_d;
      act_q  <= act_d;
    end
  end

  assign lim_o  = lim_q;
  assign lost_o = lost_q;
  assign sys_o  = sys_q;
  assign req_o  = req_q;
  assign act_o  = act_q;

  assert_lost_needs_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(lim_q));
  assert_poll_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && req_q && !clear_i) |=> (act_q && !req_q));
  assert_setint_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (setint_i && !clear_i && !take) |=> (sys_q && req_q));
  assert_eoi_clears_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !clear_i && !poll_i && !setint_i) |=> !act_q);
  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i && clr_all_i && !hit_i && !setint_i) |=> (!lim_q && !lost_q && !sys_q));
endmodule

// File: rtl/lcc_clock_if.sv
module lcc_clock_if
  import lcc_pkg::*;
#(
  parameter int          COUNT_W  = 24,
  parameter int          BASE_DIV = 4,
  parameter logic [15:0] DEV_NUM  = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_stb_i,
  input  logic              stat_stb_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  input  logic              setint_stb_i,
  input  logic              eoi_stb_i,
  input  logic              poll_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_req_o,
  output logic              int_ack_o,
  output logic              poll_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  ctrl_t cw;
  logic  mr, rate_ld, ctl_plain;
  logic  en_q, sel_q, crst_q;
  logic  en_d, sel_d, crst_d, ctrl_en;

  assign cw        = ctrl_t'(data_i[CTRL_W-1:0]);
  assign rate_ld   = ctl_stb_i && cw.rate_load;
  assign mr        = ctl_stb_i && !cw.rate_load && cw.mreset;
  assign ctl_plain = ctl_stb_i && !mr;

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    crst_d  = crst_q;
    ctrl_en = 1'b0;
    if (mr) begin
      en_d    = 1'b0;
      sel_d   = 1'b0;
      crst_d  = 1'b0;
      ctrl_en = 1'b1;
    end else if (ctl_stb_i) begin
      en_d    = cw.irq_en;
      sel_d   = cw.wr_sel;
      crst_d  = cw.cnt_rst;
      ctrl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      crst_q <= 1'b0;
    end else if (ctrl_en) begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      crst_q <= crst_d;
    end
  end

  logic [RATE_W-1:0] rate;
  logic              tick, hit;
  logic [DATA_W-1:0] cnt_lo;
  logic              lim, lost, sys, req, act;

  lcc_tick_div #(.RATE_W(RATE_W), .BASE_DIV(BASE_DIV)) u_div (
    .clk(clk), .rst_n(rst_sn), .clear_i(mr), .load_i(rate_ld),
    .rate_i(cw.rate), .rate_o(rate), .tick_o(tick)
  );

  lcc_count_cmp #(.COUNT_W(COUNT_W), .LIM_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .clear_i(mr), .tick_i(tick),
    .wr_i(wr_stb_i), .wr_sel_i(sel_q), .cnt_rst_i(crst_q),
    .wdata_i(data_i), .cnt_lo_o(cnt_lo), .hit_o(hit)
  );

  lcc_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_sn), .clear_i(mr), .ctl_i(ctl_plain),
    .clr_all_i(cw.clr_all), .clr_one_i(cw.clr_one), .clr_code_i(cw.clr_code),
    .irq_en_i(en_d), .setint_i(setint_stb_i), .poll_i(poll_i),
    .eoi_i(eoi_stb_i), .hit_i(hit),
    .lim_o(lim), .lost_o(lost), .sys_o(sys), .req_o(req), .act_o(act)
  );

  logic [DATA_W-1:0] status;
  always_comb begin
    status            = '0;
    status[ST_OK_BIT] = 1'b1;
    status[RATE_W-1:0] = rate;
    status[3]         = lim;
    status[4]         = lost;
    status[5]         = sys;
    status[6]         = sel_q;
    status[7]         = crst_q;
  end

  always_comb begin
    data_o = '0;
    if (stat_stb_i)          data_o = status;
    else if (rd_stb_i)       data_o = cnt_lo;
    else if (poll_i && req)  data_o = DEV_NUM;
  end

  assign irq_req_o = req;
  assign int_ack_o = poll_i && req;
  assign poll_o    = poll_i && !req;

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({ctl_stb_i, stat_stb_i, rd_stb_i, wr_stb_i, setint_stb_i, eoi_stb_i, poll_i}));
  assert_mreset_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    mr |=> (rate == '0 && !en_q && !sel_q && !crst_q && !irq_req_o));
  assert_active_holds_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (act && !eoi_stb_i && !mr) |=> act);
endmodule

// File: tb/lcc_clock_if_bench.sv
module lcc_clock_if_bench;
  localparam int          COUNT_W  = 24;
  localparam int          BASE_DIV = 4;
  localparam logic [15:0] DEV_NUM  = 16'h0005;

  // strobe kinds
  localparam int K_IDLE = 0, K_CTL = 1, K_STAT = 2, K_RD = 3, K_WR = 4,
                 K_SET = 5, K_EOI = 6, K_POLL = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_stb_i = 0, stat_stb_i = 0, rd_stb_i = 0, wr_stb_i = 0;
  logic        setint_stb_i = 0, eoi_stb_i = 0, poll_i = 0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        irq_req_o, int_ack_o, poll_o;

  always #4 clk = ~clk;

  lcc_clock_if #(.COUNT_W(COUNT_W), .BASE_DIV(BASE_DIV), .DEV_NUM(DEV_NUM)) u_lcc_clock_if (
    .clk(clk), .rst_n(rst_n), .ctl_stb_i(ctl_stb_i), .stat_stb_i(stat_stb_i),
    .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .setint_stb_i(setint_stb_i),
    .eoi_stb_i(eoi_stb_i), .poll_i(poll_i), .data_i(data_i), .data_o(data_o),
    .irq_req_o(irq_req_o), .int_ack_o(int_ack_o), .poll_o(poll_o)
  );

  // behavioural reference state
  int     m_rate, m_div;
  longint m_count, m_limit;
  bit     m_en, m_sel, m_crst, m_lim, m_lost, m_sys, m_req, m_act;
  int     n_vec = 0, n_bad = 0;
  bit     done = 0;
  longint cmask = (longint'(1) << COUNT_W) - 1;

  function automatic int period(int r);
    return (r == 0) ? 0 : (BASE_DIV << (r - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = 0; m_div = 0; m_count = 0; m_limit = 0;
      m_en = 0; m_sel = 0; m_crst = 0;
      m_lim = 0; m_lost = 0; m_sys = 0; m_req = 0; m_act = 0;
    end else begin
      bit ld, mrs, tk, tku, ht, l, o, s, en_n, recomp;
      longint nxt;
      ld  = ctl_stb_i && data_i[3];
      mrs = ctl_stb_i && !data_i[3] && data_i[4];
      tk  = (m_rate != 0) && (m_div == period(m_rate) - 1) && !ld && !mrs;
      tku = tk && !wr_stb_i;
      nxt = (m_count + 1) & cmask;
      ht  = tku && (nxt == m_limit);
      en_n = mrs ? 0 : (ctl_stb_i ? data_i[5] : m_en);
      l = m_lim; o = m_lost; s = m_sys;
      if (mrs) begin
        l = 0; o = 0; s = 0;
      end else begin
        if (ctl_stb_i) begin
          if (data_i[8]) begin l = 0; o = 0; s = 0; end
          else if (data_i[9]) begin
            if (data_i[11:10] == 1) l = 0;
            if (data_i[11:10] == 2) o = 0;
            if (data_i[11:10] == 3) s = 0;
          end
        end
        if (setint_stb_i) s = 1;
        if (ht) begin
          if (l) o = 1;
          l = 1;
        end
      end
      recomp = eoi_stb_i || ((ctl_stb_i || ht) && !m_act);
      if (mrs) begin m_req = 0; m_act = 0; end
      else if (poll_i && m_req) begin m_req = 0; m_act = 1; end
      else if (setint_stb_i) m_req = 1;
      else if (recomp) begin m_act = 0; m_req = ((l || o) && en_n) || s; end
      // count / limit
      if (mrs) begin m_count = 0; m_limit = 0; end
      else if (wr_stb_i) begin
        if (m_sel) m_count = 0; else m_limit = data_i;
      end else if (tku) m_count = (ht && m_crst) ? 0 : nxt;
      // divider
      if (mrs) begin m_rate = 0; m_div = 0; end
      else if (ld) begin m_rate = data_i[2:0]; m_div = 0; end
      else if (m_rate != 0) m_div = (m_div == period(m_rate) - 1) ? 0 : m_div + 1;
      if (mrs) begin m_en = 0; m_sel = 0; m_crst = 0; end
      else if (ctl_stb_i) begin m_en = data_i[5]; m_sel = data_i[6]; m_crst = data_i[7]; end
      m_lim = l; m_lost = o; m_sys = s;
    end
  end

  task automatic check(input string tag);
    logic [15:0] ed;
    bit ea, ep;
    ed = 16'h0;
    if (stat_stb_i)
      ed = 16'h8000 | 16'(m_rate) | (16'(m_lim) << 3) | (16'(m_lost) << 4) |
           (16'(m_sys) << 5) | (16'(m_sel) << 6) | (16'(m_crst) << 7);
    else if (rd_stb_i) ed = 16'(m_count & 64'hFFFF);
    else if (poll_i && m_req) ed = DEV_NUM;
    ea = poll_i && m_req;
    ep = poll_i && !m_req;
    n_vec++;
    if (data_o !== ed || irq_req_o !== m_req || int_ack_o !== ea || poll_o !== ep) begin
      n_bad++;
      $display("FAIL %s: data=%h req=%b ack=%b pass=%b expected data=%h req=%b ack=%b pass=%b",
               tag, data_o, irq_req_o, int_ack_o, poll_o, ed, m_req, ea, ep);
    end
  endtask

  task automatic cyc(input string tag, input int kind, input logic [15:0] d);
    @(negedge clk);
    ctl_stb_i    = (kind == K_CTL);
    stat_stb_i   = (kind == K_STAT);
    rd_stb_i     = (kind == K_RD);
    wr_stb_i     = (kind == K_WR);
    setint_stb_i = (kind == K_SET);
    eoi_stb_i    = (kind == K_EOI);
    poll_i       = (kind == K_POLL);
    data_i       = d;
    #1;
    check(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, K_IDLE, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1 reset idle", 4);
    cyc("R1 status after reset", K_STAT, 16'h0);
    cyc("R1 count after reset", K_RD, 16'h0);
    cyc("R11 poll passes on", K_POLL, 16'h0);
    cyc("R7 limit load", K_WR, 16'd3);
    // rate 1, load, irq enable, count restart
    cyc("R2 rate load", K_CTL, 16'h00A9);
    idle("R8 counting to limit", 14);
    cyc("R5 status limit set", K_STAT, 16'h0);
    idle("R9 second limit event", 12);
    cyc("R9 status lost set", K_STAT, 16'h0);
    cyc("R11 poll takes request", K_POLL, 16'h0);
    idle("R10 active holds", 14);
    cyc("R10 ctl while active", K_CTL, 16'h00A0);
    idle("R10 still active", 3);
    cyc("R10 end of interrupt", K_EOI, 16'h0);
    cyc("R4 clear limit only", K_CTL, 16'h06A0);
    cyc("R4 status", K_STAT, 16'h0);
    cyc("R4 clear lost only", K_CTL, 16'h0AA0);
    cyc("R4 status", K_STAT, 16'h0);
    cyc("R4 code zero clears none", K_CTL, 16'h02A0);
    cyc("R4 status", K_STAT, 16'h0);
    cyc("R12 set interrupt", K_SET, 16'h0);
    cyc("R12 status", K_STAT, 16'h0);
    cyc("R4 clear system only", K_CTL, 16'h0EA0);
    cyc("R4 status", K_STAT, 16'h0);
    cyc("R4 clear all", K_CTL, 16'h01A0);
    cyc("R4 status", K_STAT, 16'h0);
    cyc("R2 stop clock", K_CTL, 16'h0008);
    cyc("R6 count at stop", K_RD, 16'h0);
    idle("R2 stopped", 20);
    cyc("R2 count held", K_RD, 16'h0);
    cyc("R12 set interrupt disabled", K_SET, 16'h0);
    cyc("R11 poll takes sys", K_POLL, 16'h0);
    cyc("R10 eoi recompute sys", K_EOI, 16'h0);
    cyc("R4 clear all", K_CTL, 16'h0100);
    // rate 2, no restart, limit 5
    cyc("R7 limit 5", K_WR, 16'd5);
    cyc("R2 rate 2", K_CTL, 16'h002A);
    for (int k = 0; k < 8; k++) begin
      idle("R8 free run", 7);
      cyc("R6 read count", K_RD, 16'h0);
    end
    cyc("R5 status", K_STAT, 16'h0);
    cyc("R7 select count clear", K_CTL, 16'h0060);
    idle("R8 run", 5);
    cyc("R7 clear count", K_WR, 16'h1234);
    cyc("R6 count after clear", K_RD, 16'h0);
    for (int k = 0; k < 10; k++) cyc("R7 write beside ticks", K_WR, 16'h0);
    cyc("R6 count", K_RD, 16'h0);
    cyc("R2 rate 1 restart", K_CTL, 16'h0049);
    idle("R8 run", 9);
    cyc("R6 count", K_RD, 16'h0);
    cyc("R12 set", K_SET, 16'h0);
    cyc("R3 master reset", K_CTL, 16'h0010);
    cyc("R3 status", K_STAT, 16'h0);
    cyc("R3 count", K_RD, 16'h0);
    idle("R3 stopped after reset", 10);
    cyc("R3 count held", K_RD, 16'h0);
    cyc("R11 poll passes", K_POLL, 16'h0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule